// File: doc/BRIEF.md
# Cache Control Command Engine

This block is the command side of a cache control/status register for a two-way set-associative cache. Software writes a 4-bit command code. The engine decodes it and either switches the cache on, or walks every set of the tag state one set per clock. The walk either releases all line locks or invalidates all lines. While a walk runs, a busy flag is high. Any command written during that time is dropped and sets a sticky error bit.

The tag state (two valid bits, two lock bits and one replacement bit per set) is held inside the block. It is not reset. After a power-on or hard reset the cache is off, but its previous contents can still be read through an inspection port. The fill/miss logic outside the block writes lines through a simple fill port. After reset, software is expected to issue unlock-all, then invalidate-all, then enable. The replacement bit names the way to be replaced next: 0 means way 0.

Top module: `cache_cmd_engine`

## Requirements
- R1: While `rst_n` is low at a clock edge, `cache_en`, `busy` and `cmd_err` become 0, and every valid, lock and replacement bit keeps its value across the reset.
- R2: The unlock-all command, code 4'b1010, clears both lock bits of every set. Valid and replacement bits are left as they were.
- R3: The invalidate-all command, code 4'b1100, clears both valid bits of every set and sets every replacement bit to 0 (way 0). Lock bits are left as they were.
- R4: After an accepted unlock-all or invalidate-all write, `busy` is high for exactly SETS cycles, starting in the cycle after the write. In the k-th of those cycles `walk_set` equals k-1. The strobes {`clr_valid_stb`,`clr_lock_stb`,`lru_rst_stb`} are 3'b010 for unlock and 3'b101 for invalidate, and 3'b000 whenever `busy` is low.
- R5: The enable command, code 4'b0010, written while idle sets `cache_en` in the next cycle and changes no tag state.
- R6: A write while `busy` is high is ignored, whatever its code, and sets `cmd_err`. The next accepted recognised command clears `cmd_err`.
- R7: A write of any other code while idle changes nothing: `cache_en`, `cmd_err`, `busy` and the tag state all keep their values.
- R8: A fill write to (set, way) makes that way valid, sets its lock bit to `fill_lock`, and points the set's replacement bit at the other way. When a walk strobe hits the same set in the same cycle, the walk wins.
- R9: `insp_valid`, `insp_lock` and `insp_lru` show the stored state of set `insp_set` in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | 4 | Command field being written |
| fill_en | input | 1 | Line fill write strobe |
| fill_set | input | SET_W | Set written by a fill |
| fill_way | input | 1 | Way written by a fill |
| fill_lock | input | 1 | Lock value stored by a fill |
| insp_set | input | SET_W | Set shown on the inspection outputs |
| insp_valid | output | 2 | Valid bits of the inspected set (bit = way) |
| insp_lock | output | 2 | Lock bits of the inspected set (bit = way) |
| insp_lru | output | 1 | Replacement bit of the inspected set |
| cache_en | output | 1 | Cache enabled |
| busy | output | 1 | Whole-cache walk in progress |
| cmd_err | output | 1 | Sticky error: a command arrived while busy |
| walk_set | output | SET_W | Set being processed by the walk |
| clr_valid_stb | output | 1 | Clear valid bits of `walk_set` this cycle |
| clr_lock_stb | output | 1 | Clear lock bits of `walk_set` this cycle |
| lru_rst_stb | output | 1 | Reset replacement bit of `walk_set` this cycle |

## Verification
The walks start from a cache whose sets mix valid and locked ways, with replacement bits pointing at both ways. This shows that unlock-all touches only locks and invalidate-all touches only valid and replacement bits. A reset applied over a populated cache, then read back through the inspection port, separates "disabled" from "cleared". A write made in the middle of an invalidate walk, carrying the unlock code, shows whether busy-time writes are really dropped, because the locks would change if it ran. Unknown codes written while an error is pending show whether they disturb either the enable bit or the error bit.

// File: rtl/cce_pkg.sv
// Package: shared constants and types of the cache command engine.
// Assumes a 4-bit command field and a two-way cache.
package cce_pkg;
    localparam int CMD_W    = 4;
    localparam int NUM_WAYS = 2;

    // Command codes recognised in the command field
    typedef enum logic [CMD_W-1:0] {
        CMD_ENABLE     = 4'b0010,
        CMD_UNLOCK_ALL = 4'b1010,
        CMD_INVAL_ALL  = 4'b1100
    } cmd_e;

    // Whole-cache walk kinds
    typedef enum logic {
        OP_UNLOCK = 1'b0,
        OP_INVAL  = 1'b1
    } walk_op_e;

    // Decoder result for one command write
    typedef struct packed {
        logic     start_walk;
        walk_op_e op;
        logic     set_enable;
        logic     accept;
        logic     reject;
    } dec_t;
endpackage

// File: rtl/cce_decode.sv
// Module: cce_decode
// Purely combinational. Turns a command write into actions. Assumes the
// caller supplies the current busy flag. Writes made while busy are only
// flagged as rejected. Unknown codes made while idle give no action at all.
module cce_decode
    import cce_pkg::*;
(
    input  logic             wr,
    input  logic [CMD_W-1:0] code,
    input  logic             busy,
    output dec_t             dec
);
    // Decode the command code into walk/enable/reject actions
    always_comb begin
        dec = '0;
        if (wr && busy) begin
            dec.reject = 1'b1;
        end else if (wr) begin
            case (code)
                CMD_ENABLE: begin
                    dec.set_enable = 1'b1;
                    dec.accept     = 1'b1;
                end
                CMD_UNLOCK_ALL: begin
                    dec.start_walk = 1'b1;
                    dec.op         = OP_UNLOCK;
                    dec.accept     = 1'b1;
                end
                CMD_INVAL_ALL: begin
                    dec.start_walk = 1'b1;
                    dec.op         = OP_INVAL;
                    dec.accept     = 1'b1;
                end
                default: dec = '0;
            endcase
        end
    end
endmodule

// File: rtl/cce_walker.sv
// Module: cce_walker
// Steps a set index from 0 to SETS-1, one set per clock, and drives the
// per-set strobes for the selected walk. Assumes start is only raised while
// idle. Needs SETS >= 2.
module cce_walker
    import cce_pkg::*;
#(
    parameter int SETS  = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  walk_op_e         op_in,
    output logic             busy,
    output logic [SET_W-1:0] idx,
    output logic             clr_valid,
    output logic             clr_lock,
    output logic             lru_rst
);
    localparam logic [SET_W-1:0] LAST = SET_W'(SETS - 1);

    walk_op_e op_q;

    // Walk state: start, advance one set per cycle, stop after the last set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
            op_q <= OP_UNLOCK;
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
            op_q <= op_in;
        end else if (busy) begin
            if (idx == LAST) busy <= 1'b0;
            else             idx  <= idx + 1'b1;
        end
    end

    // Strobes for the set currently addressed by the walk
    always_comb begin
        clr_lock  = busy && (op_q == OP_UNLOCK);
        clr_valid = busy && (op_q == OP_INVAL);
        lru_rst   = busy && (op_q == OP_INVAL);
    end

    AST_WALK_END: assert property (@(posedge clk) disable iff (!rst_n)
        busy && idx == LAST && !start |=> !busy);                      // R4
    AST_WALK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy && idx != LAST && !start |=> busy && idx == SET_W'($past(idx) + 1)); // R4
    AST_WALK_BEGIN: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy && idx == '0);                                  // R4
    AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clr_lock, clr_valid}));                              // R2
endmodule

// File: rtl/cce_tag_state.sv
// Module: cce_tag_state
// Holds the valid, lock and replacement bits of each set of a two-way cache.
// This storage is deliberately not reset, so that it keeps its contents
// across a reset. Walk strobes take priority over a fill to the same set.
module cce_tag_state
    import cce_pkg::*;
#(
    parameter int SETS  = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SET_W-1:0]    walk_set,
    input  logic                clr_valid,
    input  logic                clr_lock,
    input  logic                lru_rst,
    input  logic                fill_en,
    input  logic [SET_W-1:0]    fill_set,
    input  logic                fill_way,
    input  logic                fill_lock,
    input  logic [SET_W-1:0]    rd_set,
    output logic [NUM_WAYS-1:0] rd_valid,
    output logic [NUM_WAYS-1:0] rd_lock,
    output logic                rd_lru
);
    logic [NUM_WAYS-1:0] valid_q [SETS];
    logic [NUM_WAYS-1:0] lock_q  [SETS];
    logic                lru_q   [SETS];

    // Per-set update: a walk strobe wins, otherwise apply a fill
    always_ff @(posedge clk) begin
        for (int s = 0; s < SETS; s++) begin
            if (SET_W'(s) == walk_set && (clr_valid || clr_lock || lru_rst)) begin
                if (clr_valid) valid_q[s] <= '0;
                if (clr_lock)  lock_q[s]  <= '0;
                if (lru_rst)   lru_q[s]   <= 1'b0;
            end else if (fill_en && SET_W'(s) == fill_set) begin
                valid_q[s][fill_way] <= 1'b1;
                lock_q[s][fill_way]  <= fill_lock;
                lru_q[s]             <= ~fill_way;
            end
        end
    end

    // Combinational inspection read
    always_comb begin
        rd_valid = valid_q[rd_set];
        rd_lock  = lock_q[rd_set];
        rd_lru   = lru_q[rd_set];
    end

    AST_INVAL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_valid && lru_rst |=> valid_q[$past(walk_set)] == '0 && !lru_q[$past(walk_set)]); // R3
    AST_UNLOCK_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lock |=> lock_q[$past(walk_set)] == '0);                   // R2
    AST_UNLOCK_KEEPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        clr_lock && !clr_valid |=> valid_q[$past(walk_set)] == $past(valid_q[walk_set])); // R2
endmodule

// File: rtl/cache_cmd_engine.sv
// Module: cache_cmd_engine (top)
// Command engine of a cache control register. It holds the enable and error
// bits, decodes command writes, runs whole-cache walks and owns the tag
// state. It assumes a single register writer and uses a synchronous
// active-low reset, which leaves the tag state untouched.
module cache_cmd_engine
    import cce_pkg::*;
#(
    parameter int SETS  = 8,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_wr,
    input  logic [CMD_W-1:0]    cmd_code,
    input  logic                fill_en,
    input  logic [SET_W-1:0]    fill_set,
    input  logic                fill_way,
    input  logic                fill_lock,
    input  logic [SET_W-1:0]    insp_set,
    output logic [NUM_WAYS-1:0] insp_valid,
    output logic [NUM_WAYS-1:0] insp_lock,
    output logic                insp_lru,
    output logic                cache_en,
    output logic                busy,
    output logic                cmd_err,
    output logic [SET_W-1:0]    walk_set,
    output logic                clr_valid_stb,
    output logic                clr_lock_stb,
    output logic                lru_rst_stb
);
    dec_t dec;

    cce_decode u_decode (
        .wr   (cmd_wr),
        .code (cmd_code),
        .busy (busy),
        .dec  (dec)
    );

    cce_walker #(.SETS(SETS)) u_walker (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (dec.start_walk),
        .op_in     (dec.op),
        .busy      (busy),
        .idx       (walk_set),
        .clr_valid (clr_valid_stb),
        .clr_lock  (clr_lock_stb),
        .lru_rst   (lru_rst_stb)
    );

    cce_tag_state #(.SETS(SETS)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .walk_set  (walk_set),
        .clr_valid (clr_valid_stb),
        .clr_lock  (clr_lock_stb),
        .lru_rst   (lru_rst_stb),
        .fill_en   (fill_en),
        .fill_set  (fill_set),
        .fill_way  (fill_way),
        .fill_lock (fill_lock),
        .rd_set    (insp_set),
        .rd_valid  (insp_valid),
        .rd_lock   (insp_lock),
        .rd_lru    (insp_lru)
    );

    // Enable bit: cleared by reset, set by the enable command
    always_ff @(posedge clk) begin
        if (!rst_n)              cache_en <= 1'b0;
        else if (dec.set_enable) cache_en <= 1'b1;
    end

    // Sticky error: set by a write while busy, cleared by an accepted command
    always_ff @(posedge clk) begin
        if (!rst_n)          cmd_err <= 1'b0;
        else if (dec.reject) cmd_err <= 1'b1;
        else if (dec.accept) cmd_err <= 1'b0;
    end

    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        busy && cmd_wr |=> cmd_err && $stable(cache_en));              // R6
    AST_ENABLE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_wr && cmd_code == CMD_ENABLE |=> cache_en && !cmd_err && !busy); // R5
    AST_UNKNOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && cmd_wr && cmd_code != CMD_ENABLE && cmd_code != CMD_UNLOCK_ALL
        && cmd_code != CMD_INVAL_ALL |=> $stable(cache_en) && $stable(cmd_err) && !busy); // R7
    AST_IDLE_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !clr_valid_stb && !clr_lock_stb && !lru_rst_stb);    // R4
endmodule

// File: tb/cache_cmd_engine_test.sv
// Scoreboard bench: driver tasks push expected items, a monitor on the
// falling edge pops them and compares them with the ports.
module cache_cmd_engine_test;
    localparam int SETS  = 8;
    localparam int SET_W = $clog2(SETS);

    localparam logic [3:0] C_EN  = 4'b0010;
    localparam logic [3:0] C_UNL = 4'b1010;
    localparam logic [3:0] C_INV = 4'b1100;

    // selectors for the monitor
    localparam int S_EN = 0, S_BUSY = 1, S_ERR = 2, S_VAL = 3, S_LCK = 4,
                   S_LRU = 5, S_WSET = 6, S_STB = 7;

    logic clk = 1'b0, rst_n = 1'b0, cmd_wr = 1'b0;
    logic [3:0] cmd_code = '0;
    logic fill_en = 1'b0, fill_way = 1'b0, fill_lock = 1'b0;
    logic [SET_W-1:0] fill_set = '0, insp_set = '0;
    logic [1:0] insp_valid, insp_lock;
    logic insp_lru, cache_en, busy, cmd_err;
    logic [SET_W-1:0] walk_set;
    logic clr_valid_stb, clr_lock_stb, lru_rst_stb;

    cache_cmd_engine #(.SETS(SETS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .fill_en(fill_en), .fill_set(fill_set), .fill_way(fill_way),
        .fill_lock(fill_lock), .insp_set(insp_set), .insp_valid(insp_valid),
        .insp_lock(insp_lock), .insp_lru(insp_lru), .cache_en(cache_en),
        .busy(busy), .cmd_err(cmd_err), .walk_set(walk_set),
        .clr_valid_stb(clr_valid_stb), .clr_lock_stb(clr_lock_stb),
        .lru_rst_stb(lru_rst_stb)
    );

    always #4 clk = ~clk;   // 125 MHz

    typedef struct {
        string req;
        int    sel;
        int    set;
        int    exp;
    } item_t;

    item_t q[$];
    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // model of the tag state
    logic [1:0] mv [SETS];
    logic [1:0] ml [SETS];
    logic       mr [SETS];

    function automatic int actual(int sel);
        case (sel)
            S_EN:   return int'(cache_en);
            S_BUSY: return int'(busy);
            S_ERR:  return int'(cmd_err);
            S_VAL:  return int'(insp_valid);
            S_LCK:  return int'(insp_lock);
            S_LRU:  return int'(insp_lru);
            S_WSET: return int'(walk_set);
            default: return int'({clr_valid_stb, clr_lock_stb, lru_rst_stb});
        endcase
    endfunction

    // monitor: pop and compare on the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            insp_set = SET_W'(it.set);
            #1;
            n_checks++;
            if (actual(it.sel) != it.exp) begin
                n_fail++;
                $display("FAIL %s sel=%0d set=%0d actual=%0d expected=%0d",
                         it.req, it.sel, it.set, actual(it.sel), it.exp);
            end
        end
    end

    task automatic push(string req, int sel, int set, int exp);
        item_t it;
        it.req = req; it.sel = sel; it.set = set; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic issue(logic [3:0] c);
        @(posedge clk); #1;
        cmd_wr = 1'b1; cmd_code = c;
        @(posedge clk); #1;
        cmd_wr = 1'b0; cmd_code = '0;
    endtask

    task automatic fill(int s, logic w, logic lk);
        @(posedge clk); #1;
        fill_en = 1'b1; fill_set = SET_W'(s); fill_way = w; fill_lock = lk;
        @(posedge clk); #1;
        fill_en = 1'b0;
        mv[s][w] = 1'b1; ml[s][w] = lk; mr[s] = ~w;
    endtask

    // scan every set against the model, one set per cycle
    task automatic scan(string req);
        for (int s = 0; s < SETS; s++) begin
            push(req, S_VAL, s, int'(mv[s]));
            push(req, S_LCK, s, int'(ml[s]));
            push(req, S_LRU, s, int'(mr[s]));
            step();
        end
    endtask

    // called right after issue() of a walk command: follow the walk
    task automatic follow_walk(int stb);
        for (int i = 0; i < SETS; i++) begin
            push("R4", S_BUSY, 0, 1);
            push("R4", S_WSET, 0, i);
            push("R4", S_STB, 0, stb);
            step();
        end
        push("R4", S_BUSY, 0, 0);
        push("R4", S_STB, 0, 0);
        step();
    endtask

    task automatic status(string req, int en, int bsy, int err);
        push(req, S_EN, 0, en);
        push(req, S_BUSY, 0, bsy);
        push(req, S_ERR, 0, err);
        step();
    endtask

    initial begin
        // R1: reset state of the control bits
        repeat (3) step();
        status("R1", 0, 0, 0);
        rst_n = 1'b1;
        step();

        // start-up sequence: unlock-all then invalidate-all
        issue(C_UNL);
        follow_walk(3'b010);
        issue(C_INV);
        follow_walk(3'b101);
        for (int s = 0; s < SETS; s++) begin
            mv[s] = '0; ml[s] = '0; mr[s] = 1'b0;
        end
        scan("R3");

        // R8: fills populate mixed state
        fill(0, 1'b0, 1'b1);
        fill(0, 1'b1, 1'b0);
        fill(3, 1'b1, 1'b1);
        fill(5, 1'b1, 1'b1);
        fill(7, 1'b0, 1'b0);
        fill(6, 1'b0, 1'b1);
        scan("R8");

        // R1: reset over a populated cache keeps the contents
        rst_n = 1'b0;
        step(); step();
        status("R1", 0, 0, 0);
        rst_n = 1'b1;
        step();
        scan("R1");

        // R5: enable sets cache_en without touching tags
        issue(C_EN);
        status("R5", 1, 0, 0);
        scan("R5");

        // R2: unlock-all clears locks only
        issue(C_UNL);
        follow_walk(3'b010);
        for (int s = 0; s < SETS; s++) ml[s] = '0;
        scan("R2");

        // R6: unlock written during an invalidate walk is dropped
        fill(2, 1'b1, 1'b1);
        fill(4, 1'b0, 1'b1);
        issue(C_INV);
        issue(C_UNL);
        repeat (SETS) step();
        status("R6", 1, 0, 1);
        for (int s = 0; s < SETS; s++) begin
            mv[s] = '0; mr[s] = 1'b0;
        end
        scan("R6");

        // R7: unknown codes while idle leave everything as it was
        issue(4'b0111);
        status("R7", 1, 0, 1);
        issue(4'b0000);
        status("R7", 1, 0, 1);
        scan("R7");

        // R6: an accepted command clears the error
        issue(C_EN);
        status("R6", 1, 0, 0);

        // R9: inspection follows insp_set without a clock (set 4 vs 2)
        push("R9", S_LCK, 4, 1);
        push("R9", S_LCK, 2, 2);
        push("R9", S_LCK, 0, 0);
        step();

        // R1: reset turns off an enabled cache
        rst_n = 1'b0;
        step(); step();
        status("R1", 0, 0, 0);
        rst_n = 1'b1;
        step();
        scan("R1");

        step(); step();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // watchdog
    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule